// File: doc/BRIEF.md
# Pseudo-SRAM Power-Down Retention Controller

This block governs the low-power idle behaviour of a 128 Mbit pseudo-SRAM organised as 8M words of 16 bits. It watches the chip-enable-2 pin through a two-stage synchroniser. On a clean falling edge it either parks the device in power-down or, when the retention-enable bit is clear, issues a one-clock reset to the asynchronous standby state. A configuration load strobe selects one of four retention modes: none, or the lowest 1M, 2M or 4M words of the array. When power-down starts, every part of the array outside the chosen window is marked as lost.

Validity is kept per tile of 2^TILE_LOG2 words, 16K words by default. Power-up clears every tile. A write-notify pulse marks the tile of the written word as holding data again. A query port takes a word address and returns, one clock later, whether that word's tile still holds valid contents. The rest of the device uses the power-down flag and the standby-reset pulse.

Top module: `psram_pd_ctrl`

## Requirements
- R1: Reset is synchronous and active high. After reset, power_down and async_standby_reset are 0 and retained is 0 for every address. The retention mode is none (code 00) and the retention-enable bit is 1, with no configuration load needed.
- R2: With retention enabled, power_down rises on the third rising clock edge after ce2_pin falls, because of the two synchroniser stages and one state register. It stays 1 while ce2_pin is low and clears on the third rising edge after ce2_pin rises.
- R3: With the retention-enable bit 0, a ce2_pin fall makes async_standby_reset 1 for exactly one clock, at the same latency as in R2. power_down stays 0 and no tile's validity changes.
- R4: A cfg_load pulse takes cfg_mode and cfg_ra only while power_down is 0; during power-down it is ignored. Mode codes: 00 = no retention, 01 = words below 100000h, 10 = words below 200000h, 11 = words below 400000h.
- R5: A power-down entry in mode 00 marks every tile invalid.
- R6: A power-down entry in modes 01, 10 or 11 keeps the validity of tiles whose base address is below the mode's limit, and marks every tile at or above the limit invalid.
- R7: wr_notify with power_down 0 marks the tile wr_addr >> TILE_LOG2 valid at the next edge. During power-down it has no effect.
- R8: retained is registered. After a rising edge it shows the validity of tile q_addr >> TILE_LOG2 as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce2_pin | input | 1 | Asynchronous chip-enable-2 pin; low requests power-down |
| cfg_load | input | 1 | Configuration load strobe |
| cfg_mode | input | 2 | Retention mode code |
| cfg_ra | input | 1 | Retention-enable bit |
| wr_notify | input | 1 | A word has been written |
| wr_addr | input | 23 | Word address of the write |
| q_addr | input | 23 | Word address to query |
| power_down | output | 1 | Device is in power-down |
| async_standby_reset | output | 1 | One-clock reset to asynchronous standby |
| retained | output | 1 | Queried word holds valid data |

## Verification
The embedded assertions check on every cycle the properties that hold at any moment. The standby-reset pulse lasts one clock and never overlaps power-down. Configuration stays frozen while the device is powered down. Power-down is only entered with retention enabled. A no-retention entry clears the whole map, and an accepted write sets its tile. What the bench scenarios alone can show is the end-to-end behaviour. That covers the exact three-edge latency from the pin and window boundaries such as 0FFFFFh against 100000h. It also covers the claims that a load or a write during power-down is ignored, which becomes visible only at a later query or a later power-down.

// File: rtl/psram_pd_pkg.sv
package psram_pd_pkg;
  typedef enum logic [1:0] {
    RET_NONE = 2'b00,
    RET_1M   = 2'b01,
    RET_2M   = 2'b10,
    RET_4M   = 2'b11
  } ret_mode_e;
endpackage

// File: rtl/ce2_edge_sync.sv
module ce2_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic fall,
  output logic rise
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= pin;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign fall = prev_q & ~s2_q;
  assign rise = ~prev_q & s2_q;
endmodule

// File: rtl/pd_mode_ctrl.sv
module pd_mode_ctrl
  import psram_pd_pkg::*;
#(
  parameter int ADDR_W    = 23,
  parameter int PART_LOG2 = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fall,
  input  logic            rise,
  input  logic            cfg_load,
  input  logic [1:0]      cfg_mode,
  input  logic            cfg_ra,
  output logic            power_down,
  output logic            stby_rst,
  output logic            inval,
  output logic [ADDR_W:0] keep_lim
);
  localparam int LW = ADDR_W + 1;

  ret_mode_e mode_q;
  logic      ra_q, pd_q, stby_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= RET_NONE;
      ra_q   <= 1'b1;
      pd_q   <= 1'b0;
      stby_q <= 1'b0;
    end else begin
      stby_q <= fall & ~ra_q & ~pd_q;
      if (fall && ra_q) pd_q <= 1'b1;
      else if (rise)    pd_q <= 1'b0;
      if (cfg_load && !pd_q) begin
        mode_q <= ret_mode_e'(cfg_mode);
        ra_q   <= cfg_ra;
      end
    end
  end

  always_comb begin
    case (mode_q)
      RET_1M:  keep_lim = LW'(1) << PART_LOG2;
      RET_2M:  keep_lim = LW'(1) << (PART_LOG2 + 1);
      RET_4M:  keep_lim = LW'(1) << (PART_LOG2 + 2);
      default: keep_lim = '0;
    endcase
  end

  assign inval      = fall & ra_q & ~pd_q;
  assign power_down = pd_q;
  assign stby_rst   = stby_q;

  assert_stby_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    stby_q |=> !stby_q);
  assert_stby_not_pd_R3: assert property (@(posedge clk) disable iff (rst)
    stby_q |-> !pd_q);
  assert_cfg_frozen_R4: assert property (@(posedge clk) disable iff (rst)
    (pd_q && $past(pd_q)) |-> ($stable(mode_q) && $stable(ra_q)));
  assert_pd_needs_ra_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_q) |-> ra_q);
  assert_pd_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (pd_q && !rise) |=> pd_q);
endmodule

// File: rtl/tile_valid_map.sv
module tile_valid_map #(
  parameter int ADDR_W    = 23,
  parameter int TILE_LOG2 = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inval,
  input  logic [ADDR_W:0]   keep_lim,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] q_addr,
  output logic              retained
);
  localparam int TB = ADDR_W - TILE_LOG2;
  localparam int NT = 1 << TB;
  localparam int LW = ADDR_W + 1;

  logic [NT-1:0] valid_q;
  logic [TB-1:0] wr_tile, q_tile;
  logic          ret_q;

  assign wr_tile = wr_addr[ADDR_W-1:TILE_LOG2];
  assign q_tile  = q_addr[ADDR_W-1:TILE_LOG2];

  logic unused_low;
  assign unused_low = ^{wr_addr[TILE_LOG2-1:0], q_addr[TILE_LOG2-1:0]};

  for (genvar t = 0; t < NT; t++) begin : g_tile
    localparam logic [LW-1:0] TBASE = LW'(t) << TILE_LOG2;
    always_ff @(posedge clk) begin
      if (rst)
        valid_q[t] <= 1'b0;
      else if (inval && (TBASE >= keep_lim))
        valid_q[t] <= 1'b0;
      else if (wr_en && (wr_tile == TB'(t)))
        valid_q[t] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ret_q <= 1'b0;
    else     ret_q <= valid_q[q_tile];
  end

  assign retained = ret_q;

  assert_none_clears_all_R5: assert property (@(posedge clk) disable iff (rst)
    (inval && keep_lim == '0) |=> (valid_q == '0));
  assert_write_sets_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !inval) |=> valid_q[$past(wr_tile)]);
endmodule

// File: rtl/psram_pd_ctrl.sv
module psram_pd_ctrl #(
  parameter int ADDR_W    = 23,
  parameter int TILE_LOG2 = 14,
  parameter int PART_LOG2 = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce2_pin,
  input  logic              cfg_load,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_ra,
  input  logic              wr_notify,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] q_addr,
  output logic              power_down,
  output logic              async_standby_reset,
  output logic              retained
);
  logic            fall, rise, inval;
  logic [ADDR_W:0] keep_lim;

  ce2_edge_sync i_sync (
    .clk(clk), .rst(rst), .pin(ce2_pin), .fall(fall), .rise(rise)
  );

  pd_mode_ctrl #(.ADDR_W(ADDR_W), .PART_LOG2(PART_LOG2)) i_mode (
    .clk(clk), .rst(rst), .fall(fall), .rise(rise),
    .cfg_load(cfg_load), .cfg_mode(cfg_mode), .cfg_ra(cfg_ra),
    .power_down(power_down), .stby_rst(async_standby_reset),
    .inval(inval), .keep_lim(keep_lim)
  );

  tile_valid_map #(.ADDR_W(ADDR_W), .TILE_LOG2(TILE_LOG2)) i_map (
    .clk(clk), .rst(rst), .inval(inval), .keep_lim(keep_lim),
    .wr_en(wr_notify & ~power_down), .wr_addr(wr_addr),
    .q_addr(q_addr), .retained(retained)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!power_down && !async_standby_reset && !retained));
endmodule

// File: tb/test_psram_pd_ctrl.sv
module test_psram_pd_ctrl;
  localparam int AW = 23;
  localparam int TL = 14;
  localparam int NT = 1 << (AW - TL);

  logic clk = 0, rst = 1, ce2_pin = 1, cfg_load = 0, cfg_ra = 0, wr_notify = 0;
  logic [1:0] cfg_mode = 0;
  logic [AW-1:0] wr_addr = 0, q_addr = 0;
  logic power_down, async_standby_reset, retained;

  int checks = 0, fails = 0;
  bit done = 0;
  bit valid_m [NT];
  int mode_m;
  bit ra_m, pd_m;

  always #10 clk = ~clk;

  psram_pd_ctrl i_psram_pd_ctrl (
    .clk(clk), .rst(rst), .ce2_pin(ce2_pin), .cfg_load(cfg_load),
    .cfg_mode(cfg_mode), .cfg_ra(cfg_ra), .wr_notify(wr_notify),
    .wr_addr(wr_addr), .q_addr(q_addr), .power_down(power_down),
    .async_standby_reset(async_standby_reset), .retained(retained)
  );

  function automatic int exp_lim(int m);
    return (m == 0) ? 0 : (1 << (19 + m));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic query(logic [AW-1:0] a, string req);
    q_addr = a;
    step(1);
    chk(retained == valid_m[a >> TL], req, retained, valid_m[a >> TL]);
  endtask

  task automatic write(logic [AW-1:0] a);
    wr_notify = 1; wr_addr = a;
    step(1);
    wr_notify = 0;
    if (!pd_m) valid_m[a >> TL] = 1;
  endtask

  task automatic load(int m, bit ra);
    cfg_load = 1; cfg_mode = 2'(m); cfg_ra = ra;
    step(1);
    cfg_load = 0;
    if (!pd_m) begin mode_m = m; ra_m = ra; end
  endtask

  task automatic ce2_low();
    ce2_pin = 0;
    step(3);
    if (ra_m) begin
      pd_m = 1;
      for (int t = 0; t < NT; t++)
        if ((t << TL) >= exp_lim(mode_m)) valid_m[t] = 0;
    end
    chk(power_down == pd_m, "R2 pd entry", power_down, pd_m);
    chk(async_standby_reset == !ra_m, "R3 standby pulse", async_standby_reset, !ra_m);
    step(1);
    chk(async_standby_reset == 0, "R3 pulse one cycle", async_standby_reset, 0);
    chk(power_down == pd_m, "R2 pd held", power_down, pd_m);
  endtask

  task automatic ce2_high();
    ce2_pin = 1;
    step(2);
    chk(power_down == pd_m, "R2 exit latency", power_down, pd_m);
    step(1);
    pd_m = 0;
    chk(power_down == 0, "R2 pd exit", power_down, 0);
  endtask

  function automatic logic [AW-1:0] rnd_addr();
    int r = $urandom_range(0, 3);
    case (r)
      0: return AW'(32'h0FFFFF + $urandom_range(0, 1));
      1: return AW'(32'h1FFFFF + $urandom_range(0, 1));
      2: return AW'(32'h3FFFFF + $urandom_range(0, 1));
      default: return AW'($urandom);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    mode_m = 0; ra_m = 1; pd_m = 0;
    for (int t = 0; t < NT; t++) valid_m[t] = 0;
    step(3);
    rst = 0;
    step(1);
    // R1 reset state
    chk(power_down == 0, "R1 pd reset", power_down, 0);
    chk(async_standby_reset == 0, "R1 stby reset", async_standby_reset, 0);
    query(23'h000000, "R1 retained reset");
    query(23'h7FFFFF, "R1 retained reset top");
    // R7/R8 writes then query
    write(23'h000010); write(23'h0FFFFF); write(23'h100000); write(23'h3FFFFF);
    query(23'h000000, "R8 query after write");
    query(23'h100005, "R7 write sets tile");
    // R1/R5 default mode none with retention enabled: all lost
    ce2_low(); ce2_high();
    query(23'h000010, "R5 none clears low");
    query(23'h3FFFFF, "R5 none clears high");
    // R6 1M window boundary
    load(1, 1);
    write(23'h0FFFFF); write(23'h100000); write(23'h000000);
    ce2_low();
    // R7 ignored during pd, R4 load ignored
    write(23'h500000);
    load(3, 0);
    query(23'h0FFFFF, "R6 1M keep edge");
    query(23'h100000, "R6 1M drop edge");
    query(23'h500000, "R7 write ignored in pd");
    ce2_high();
    query(23'h000000, "R6 1M keep base");
    // R4: old mode 01 with RA 1 still in force
    write(23'h1FFFFF);
    ce2_low();
    query(23'h1FFFFF, "R4 load ignored in pd");
    ce2_high();
    // R3 RA=0 keeps validity
    load(3, 0);
    write(23'h3FFFFF); write(23'h400000);
    ce2_low();
    query(23'h400000, "R3 validity unchanged");
    ce2_high();
    // random mix
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 99);
      if (op < 40) write(rnd_addr());
      else if (op < 75) query(rnd_addr(), "R8 random query");
      else if (op < 88) load($urandom_range(0, 3), ($urandom_range(0, 3) != 0));
      else begin
        ce2_low();
        if (pd_m) begin
          write(rnd_addr());
          load($urandom_range(0, 3), $urandom_range(0, 1));
          query(rnd_addr(), "R6 random in pd");
        end
        ce2_high();
        query(rnd_addr(), "R6 random after wake");
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule